// File: doc/BRIEF.md
# Binary Field Inverter (polynomial basis, Itoh-Tsujii chain)

This block computes the multiplicative inverse of an element of GF(2^M), stored in polynomial basis and reduced by a fixed irreducible trinomial or pentanomial. It raises the operand to the power 2^M - 2. To do so it first builds b = a^(2^(M-1)-1) along an addition chain that follows the binary digits of M-1. It then squares b once. In each chain step, a stored power of the operand is raised by a run of squarings and then multiplied by another stored power.

The datapath has two arithmetic units. A combinational unit raises its input to the 2^j power (1 <= j <= K) in one registered pass, so a run of s squarings costs ceil(s/K) cycles. A single digit-serial multiplier takes D bits of one operand per cycle and serves every multiplication of the chain. A small controller sequences the steps. A client raises `start_i` for a cycle while the block is idle and waits for the one-cycle `done_o` pulse. The field size, the reduction polynomial, the digit width D and the group size K are fixed at build time. The default is M = 163, reduction x^163 + x^7 + x^6 + x^3 + 1, K = 4, D = 16.

Top module: `gf2m_inverter`

## Requirements
- R1: For a nonzero operand a, the field product of `inverse_o` and a, reduced by the configured polynomial, equals 1 in the cycle where `done_o` is high.
- R2: An operand of zero yields `inverse_o` equal to zero when `done_o` pulses. No other indication is given.
- R3: If `start_i` is sampled at a rising edge while idle, `done_o` is high exactly L cycles later. L = 1 + sum over chain steps of (ceil(s/K) + ceil(M/D) + 2). Each chain step is either a doubling n -> 2n with s = n, or an increment n -> n+1 with s = 1. The chain starts at n = 1 and, for each bit of M-1 below its top bit (most significant first), takes one doubling and then one increment if that bit is 1. The default gives L = 163.
- R4: `done_o` is high for one cycle per accepted operation and low at every other time.
- R5: `inverse_o` keeps its value from the `done_o` cycle until a later operation completes.
- R6: A `start_i` pulse while an operation is in progress is ignored: the running operation keeps its operand and its timing.
- R7: After reset, `done_o` is low and `inverse_o` is zero.
- R8: A start may be accepted in the same cycle where `done_o` is high, and that operation follows the same timing as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an inversion; sampled only while idle |
| operand_i | input | M | Element to invert, polynomial basis |
| done_o | output | 1 | One-cycle pulse when `inverse_o` is valid |
| inverse_o | output | M | Inverse of the accepted operand, held until the next result |

## Verification
Each result is due a fixed L cycles after the edge that accepts the start: 163 cycles in the default build. The bench derives L from the chain rule, the digit count and the group size. Its model sets a countdown to L at the accepting edge and decrements it on every edge. On each falling edge it compares `done_o` against the countdown reaching zero, so an early, late or repeated pulse is caught in the cycle where it happens. Only in the `done_o` cycle is the result checked, through a bit-serial product with the stored operand. In every idle cycle the held result is compared with the last one.

// File: rtl/itinv_pkg.sv
// Shared types for the binary field inverter.
// Assumes: nothing beyond IEEE 1800-2017.
package itinv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,  // waiting for start
        ST_SQR,   // squaring passes through the 2^j power unit
        ST_MST,   // launch of the shared multiplier
        ST_MWT,   // waiting for the product
        ST_LAST   // final single squaring
    } ctl_st_t;
endpackage

// File: rtl/itinv_pow2k.sv
// Raises the operand to the 2^j power, 1 <= j <= K, in one combinational pass.
// Each squaring spreads the bits and folds the upper half back with the
// reduction terms, so it is pure XOR logic.
// Assumes: RED holds the reduction polynomial without its x^M term, and cnt_i is in 1..K.
module itinv_pow2k #(
    parameter int M = 163,
    parameter logic [M-1:0] RED = M'('hC9),
    parameter int K = 4,
    parameter int SW = $clog2(K + 1)
) (
    input  logic [M-1:0]  op_i,
    input  logic [SW-1:0] cnt_i,
    output logic [M-1:0]  pow_o
);
    // squaring modulo the fixed polynomial
    function automatic logic [M-1:0] gf_sq(input logic [M-1:0] v);
        logic [2*M-2:0] w;
        w = '0;
        for (int i = 0; i < M; i++) w[2*i] = v[i];
        for (int j = 2*M-2; j >= M; j--) begin
            if (w[j]) begin
                w[j] = 1'b0;
                w[j-M +: M] = w[j-M +: M] ^ RED;
            end
        end
        return w[M-1:0];
    endfunction

    logic [M-1:0] stage [K+1];
    assign stage[0] = op_i;

    for (genvar g = 0; g < K; g++) begin : g_sq
        assign stage[g+1] = gf_sq(stage[g]);
    end

    // selects the tap after cnt_i squarings
    always_comb begin
        pow_o = stage[1];
        for (int g = 1; g <= K; g++) begin
            if (cnt_i == SW'(g)) pow_o = stage[g];
        end
    end
endmodule

// File: rtl/itinv_dsmul.sv
// Digit-serial field multiplier, most significant digit first.
// The b operand is zero-padded to NDIG*D bits. One digit is consumed per cycle,
// and rdy_o pulses one cycle after the last digit.
// Assumes: go_i is raised only while no product is in flight.
module itinv_dsmul #(
    parameter int M = 163,
    parameter logic [M-1:0] RED = M'('hC9),
    parameter int D = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic [M-1:0] prod_o,
    output logic         rdy_o
);
    localparam int NDIG = (M + D - 1) / D;
    localparam int BW   = NDIG * D;
    localparam int CW   = $clog2(NDIG + 1);

    logic [M-1:0]  areg;
    logic [BW-1:0] breg;
    logic [M-1:0]  acc;
    logic [CW-1:0] cnt;
    logic          rdy;

    // acc * x^D + a * digit, Horner form over the digit bits
    function automatic logic [M-1:0] mac(input logic [M-1:0] ac,
                                         input logic [M-1:0] a,
                                         input logic [D-1:0] dig);
        logic [M-1:0] r;
        r = ac;
        for (int j = D-1; j >= 0; j--) begin
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? RED : '0);
            if (dig[j]) r = r ^ a;
        end
        return r;
    endfunction

    // loads operands on go_i, then accumulates one digit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            areg <= '0;
            breg <= '0;
            acc  <= '0;
            cnt  <= '0;
            rdy  <= 1'b0;
        end else begin
            rdy <= 1'b0;
            if (go_i) begin
                areg <= a_i;
                breg <= BW'(b_i);
                acc  <= '0;
                cnt  <= CW'(NDIG);
            end else if (cnt != '0) begin
                acc  <= mac(acc, areg, breg[BW-1 -: D]);
                breg <= breg << D;
                cnt  <= cnt - CW'(1);
                rdy  <= (cnt == CW'(1));
            end
        end
    end

    assign prod_o = acc;
    assign rdy_o  = rdy;

    // the shared unit is never relaunched while a product is in flight
    p_go_when_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (cnt == '0));
endmodule

// File: rtl/itinv_ctl.sv
// Sequencer for the inversion chain. It walks the bits of M-1 below the top bit.
// Each bit gives a doubling step (n squarings, then a product with the current
// power), then an increment step (one squaring, then a product with the operand)
// when the bit is 1. A final squaring turns a^(2^(M-1)-1) into a^(2^M-2).
// Assumes: M >= 3 and the multiplier pulses mrdy_i once per launch.
module itinv_ctl
    import itinv_pkg::*;
#(
    parameter int M = 163,
    parameter int K = 4,
    parameter int SW = $clog2(K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [M-1:0]  opnd_i,
    output logic          done_o,
    output logic [M-1:0]  res_o,
    output logic          mgo_o,
    output logic [M-1:0]  ma_o,
    output logic [M-1:0]  mb_o,
    input  logic [M-1:0]  mprod_i,
    input  logic          mrdy_i,
    output logic [M-1:0]  pin_o,
    output logic [SW-1:0] psel_o,
    input  logic [M-1:0]  pout_i
);
    localparam int NW = $clog2(M) + 1;
    localparam logic [NW-1:0] CHAIN = NW'(M - 1);
    localparam int TOPB = $clog2(M) - 1;

    ctl_st_t       st;
    logic [M-1:0]  a_r, oth, sq, res;
    logic [NW-1:0] n, rem, bidx, nn;
    logic          inadd, done;
    logic [SW-1:0] psel;

    // squarings taken in the current pass
    always_comb begin
        psel = (rem > NW'(K)) ? SW'(K) : SW'(rem);
        nn   = inadd ? (n + NW'(1)) : (n << 1);
    end

    // step sequencing and operand routing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            a_r <= '0; oth <= '0; sq <= '0; res <= '0;
            n <= '0; rem <= '0; bidx <= '0;
            inadd <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start_i) begin
                    a_r <= opnd_i; oth <= opnd_i; sq <= opnd_i;
                    n <= NW'(1); rem <= NW'(1); bidx <= NW'(TOPB - 1);
                    inadd <= 1'b0; st <= ST_SQR;
                end
                ST_SQR: begin
                    sq  <= pout_i;
                    rem <= rem - NW'(psel);
                    if (rem <= NW'(K)) st <= ST_MST;
                end
                ST_MST: st <= ST_MWT;
                ST_MWT: if (mrdy_i) begin
                    n  <= nn;
                    sq <= mprod_i;
                    if (!inadd && CHAIN[bidx]) begin
                        rem <= NW'(1); oth <= a_r; inadd <= 1'b1; st <= ST_SQR;
                    end else if (bidx == '0) begin
                        rem <= NW'(1); st <= ST_LAST;
                    end else begin
                        bidx <= bidx - NW'(1);
                        rem <= nn; oth <= mprod_i; inadd <= 1'b0; st <= ST_SQR;
                    end
                end
                ST_LAST: begin
                    res <= pout_i; done <= 1'b1; st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mgo_o  = (st == ST_MST);
    assign ma_o   = sq;
    assign mb_o   = oth;
    assign pin_o  = sq;
    assign psel_o = psel;
    assign done_o = done;
    assign res_o  = res;

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start_i) |=> $stable(res_o));
    p_busy_ignores_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_LAST) |=> (st != ST_IDLE));
    p_zero_maps_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && a_r == '0) |-> (res_o == '0));
    p_pass_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SQR) |-> (psel >= SW'(1) && psel <= SW'(K)));
endmodule

// File: rtl/gf2m_inverter.sv
// Top of the binary field inverter: sequencer, 2^j power unit and one shared
// digit-serial multiplier. The power unit's output is registered in the sequencer.
// Assumes: RED is irreducible together with x^M, and K and D are small positive values.
module gf2m_inverter #(
    parameter int M = 163,
    parameter logic [M-1:0] RED = M'('hC9),
    parameter int K = 4,
    parameter int D = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [M-1:0] operand_i,
    output logic         done_o,
    output logic [M-1:0] inverse_o
);
    localparam int SW = $clog2(K + 1);

    logic          mgo, mrdy;
    logic [M-1:0]  ma, mb, mprod, pin, pout;
    logic [SW-1:0] psel;

    itinv_ctl #(.M(M), .K(K), .SW(SW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opnd_i(operand_i),
        .done_o(done_o), .res_o(inverse_o),
        .mgo_o(mgo), .ma_o(ma), .mb_o(mb), .mprod_i(mprod), .mrdy_i(mrdy),
        .pin_o(pin), .psel_o(psel), .pout_i(pout)
    );

    itinv_pow2k #(.M(M), .RED(RED), .K(K), .SW(SW)) u_pow (
        .op_i(pin), .cnt_i(psel), .pow_o(pout)
    );

    itinv_dsmul #(.M(M), .RED(RED), .D(D)) u_mul (
        .clk(clk), .rst_n(rst_n), .go_i(mgo), .a_i(ma), .b_i(mb),
        .prod_o(mprod), .rdy_o(mrdy)
    );
endmodule

// File: tb/sim_gf2m_inverter.sv
module sim_gf2m_inverter;
    localparam int PER = 10;
    localparam int M = 163;
    localparam logic [M-1:0] RED = M'('hC9);
    localparam int K = 4;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] opnd = '0;
    logic         done;
    logic [M-1:0] inv;

    int checks = 0;
    int failures = 0;

    gf2m_inverter #(.M(M), .RED(RED), .K(K), .D(D)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .operand_i(opnd),
        .done_o(done), .inverse_o(inv)
    );

    always #(PER/2) clk = ~clk;

    // bit-serial reference product
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0;
        for (int i = M-1; i >= 0; i--) begin
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? RED : '0);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    // latency rule of R3
    function automatic int calc_lat();
        int top = 0, n = 1, tot = 0, ndig = (M + D - 1) / D;
        for (int b = 0; b < 32; b++) if (((M - 1) >> b) & 1) top = b;
        for (int b = top - 1; b >= 0; b--) begin
            tot += (n + K - 1) / K + ndig + 2;
            n = 2 * n;
            if (((M - 1) >> b) & 1) begin
                tot += 1 + ndig + 2;
                n = n + 1;
            end
        end
        return tot + 1;
    endfunction

    localparam int LAT = calc_lat();

    task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle model: busy countdown and captured operand
    bit           mbusy = 1'b0;
    int           mcnt = 0;
    logic [M-1:0] mop = '0;
    logic [M-1:0] last_res = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mbusy = 1'b0;
            mcnt = 0;
        end else if (mbusy && mcnt != 0) begin
            mcnt--;
        end else begin
            mbusy = 1'b0;
            if (start) begin
                mbusy = 1'b1;
                mcnt = LAT;
                mop = opnd;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mbusy && mcnt == 0) begin
                chk(done == 1'b1, "R3 done due", M'(done), M'(1));
                if (mop == '0) chk(inv == '0, "R2 zero in", inv, '0);
                else chk(ref_mul(inv, mop) == M'(1), "R1 product", ref_mul(inv, mop), M'(1));
                last_res = inv;
            end else begin
                chk(done == 1'b0, "R4 stray done", M'(done), '0);
                if (!mbusy) chk(inv == last_res, "R5 hold", inv, last_res);
            end
        end
    end

    task automatic launch_now(input logic [M-1:0] v);
        start = 1'b1;
        opnd = v;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (!done && g < LAT + 20) begin
            @(negedge clk);
            g++;
        end
        chk(done == 1'b1, "R3 timeout", M'(done), M'(1));
    endtask

    function automatic logic [M-1:0] rnd();
        return M'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R7 done after reset", M'(done), '0);
        chk(inv == '0, "R7 result after reset", inv, '0);
        chk(LAT == 163, "R3 default latency", M'(LAT), M'(163));

        launch_now(M'(1)); wait_done();
        // R8: next start in the done cycle
        launch_now(M'(2)); wait_done();
        launch_now('0); wait_done();
        launch_now({M{1'b1}}); wait_done();
        repeat (7) @(negedge clk);          // R5 idle hold
        launch_now(RED); wait_done();
        for (int t = 0; t < 4; t++) begin
            launch_now(rnd()); wait_done();
            repeat (t) @(negedge clk);
        end
        // R6: second start in mid-run is ignored
        launch_now(rnd());
        repeat (20) @(negedge clk);
        start = 1'b1; opnd = rnd();
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);
        launch_now(M'(1) << (M - 1)); wait_done();
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PER * 200000);
        failures++;
        $display("FAIL R3 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule